// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block supervises a processor's activity. Software proves it is alive by toggling a kick line. Every transition counts as a kick, whichever its direction. When the kick line shows no transition for a programmed number of clock cycles, the active-low watchdog output drops. It stays low until the timer is cleared again. A typical setting is 1.6 s: roughly one to two and a quarter seconds is acceptable.

The timer is held cleared and disarmed in three cases:
- while the system reset generator reports reset active;
- while the kick line is flagged as undriven (floating or tri-stated);
- while the supply is reported bad.

After any of these it counts again only once a kick edge has been seen. Supply loss also forces the output low at once, through a combinational path. The output rises again in the same cycle that supply-OK returns. The kick input is asynchronous. It passes through a synchronizer, and edges are found by comparing the two newest synchronized samples.

Top module: `edge_watchdog`

## Requirements
- R1: During and right after `rst_n` reset, with supply OK, `wdog_n_o` is 1 and the timer is disarmed. The kick line is taken to be low at reset.
- R2: A rising or a falling edge on `kick_i` clears the count and arms the timer. A new edge before expiry restarts the full timeout.
- R3: The synchronizer adds `SYNC_STAGES` cycles of latency, and the edge is taken one cycle after that. If no further edge follows, `wdog_n_o` is high for exactly `SYNC_STAGES+TIMEOUT_CYC` clock edges after `kick_i` changes, and it is low from edge `SYNC_STAGES+TIMEOUT_CYC+1`.
- R4: Once expired, `wdog_n_o` stays low until a kick edge, a system reset, an undriven kick line or supply loss clears the timer.
- R5: While `sys_rst_act_i` is 1, the timer is cleared from the next clock edge on, and it ignores kicks. After release it stays disarmed (output high) until the first kick edge.
- R6: While `kick_drv_i` is 0, the timer is cleared and disarmed in the same way. After the line is driven again, counting needs a kick edge.
- R7: `wdog_n_o` is 0 in any cycle in which `supply_ok_i` is 0, with no clock edge needed. When `supply_ok_i` returns to 1, the output is 1 in that same cycle, and the timer is disarmed.
- R8: A kick pulse only one clock period wide is seen as two edges, and the timeout counts from the second edge.
- R9: The count saturates at `TIMEOUT_CYC` and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Asynchronous kick line, both edges count |
| kick_drv_i | input | 1 | 1 when the kick line is actively driven |
| supply_ok_i | input | 1 | 1 while the supply is above its threshold |
| sys_rst_act_i | input | 1 | 1 while the system reset generator asserts reset |
| wdog_n_o | output | 1 | Active-low watchdog timeout output |

## Verification
The checker takes `kick_drv_i`, `supply_ok_i` and `sys_rst_act_i` to be synchronous to `clk`. Only `kick_i` is asynchronous. The checker also takes the kick line to be low during reset, because no edge arrives before the first real kick. The stimulus changes every input on the falling clock edge. It keeps `kick_i` low while `rst_n` is asserted. It leaves at least four cycles between the last kick toggle and the release of any hold condition, so that no edge is still in flight in the synchronizer when counting is expected to stay off.

// File: rtl/edge_watchdog_pkg.sv
package edge_watchdog_pkg;

    // Control bundle passed from the top to the timer core.
    typedef struct packed {
        logic hold;   // clear and disarm
        logic kick;   // synchronized edge seen this cycle
    } wd_ctrl_t;

    // Bits needed to hold the value 0..limit inclusive.
    function automatic int unsigned count_bits(input longint unsigned limit);
        int unsigned n;
        n = 1;
        while ((longint'(1) << n) <= limit) n++;
        return n;
    endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic edge_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] chain;
        logic         prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d          = st_q;
                st_d.chain[0] = kick_i;
                st_d.prev     = st_q.chain[TOP];
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[TOP-1:0], kick_i};
                // previous sample tracks even while the timer is held
                st_d.prev  = st_q.chain[TOP];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o = st_q.chain[TOP] ^ st_q.prev;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import edge_watchdog_pkg::*;
#(
    parameter longint unsigned TIMEOUT_CYC = 80_000_000,
    parameter int unsigned     CNT_W       = count_bits(TIMEOUT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_ctrl_t         ctrl_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ctrl_i.hold) begin
            st_d.armed = 1'b0;
            st_d.count = '0;
        end else if (ctrl_i.kick) begin
            st_d.armed = 1'b1;
            st_d.count = '0;
        end else if (st_q.armed && (st_q.count != LIMIT)) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign expired_o = (st_q.count == LIMIT);

endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
    import edge_watchdog_pkg::*;
#(
    parameter longint unsigned TIMEOUT_CYC = 80_000_000,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic kick_drv_i,
    input  logic supply_ok_i,
    input  logic sys_rst_act_i,
    output logic wdog_n_o
);

    localparam int unsigned CNT_W = count_bits(TIMEOUT_CYC);

    logic             kick_edge;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_expired;
    wd_ctrl_t         ctrl;

    wdog_kick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick_i),
        .edge_o (kick_edge)
    );

    always_comb begin
        ctrl.hold = sys_rst_act_i | ~kick_drv_i | ~supply_ok_i;
        ctrl.kick = kick_edge;
    end

    wdog_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .count_o   (tmr_count),
        .expired_o (tmr_expired)
    );

    // supply loss acts without a clock edge
    assign wdog_n_o = supply_ok_i & ~tmr_expired;

endmodule

// File: rtl/edge_watchdog_chk.sv
module edge_watchdog_chk #(
    parameter longint unsigned TIMEOUT_CYC = 80_000_000,
    parameter int unsigned     CNT_W       = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kick_drv_i,
    input logic             supply_ok_i,
    input logic             sys_rst_act_i,
    input logic             wdog_n_o,
    input logic             kick_edge,
    input logic [CNT_W-1:0] tmr_count
);

    assert_supply_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |-> !wdog_n_o);

    assert_supply_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok_i) |-> wdog_n_o);

    assert_reset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act_i |=> (wdog_n_o || !supply_ok_i));

    assert_undriven_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_drv_i |=> (wdog_n_o || !supply_ok_i));

    assert_latched_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_n_o && supply_ok_i && kick_drv_i && !sys_rst_act_i && !kick_edge)
        |=> !wdog_n_o);

    assert_edge_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_edge && supply_ok_i && kick_drv_i && !sys_rst_act_i)
        |=> (tmr_count == '0 && wdog_n_o));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (64'(tmr_count) <= 64'(TIMEOUT_CYC)));

endmodule

bind edge_watchdog edge_watchdog_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .kick_drv_i    (kick_drv_i),
    .supply_ok_i   (supply_ok_i),
    .sys_rst_act_i (sys_rst_act_i),
    .wdog_n_o      (wdog_n_o),
    .kick_edge     (kick_edge),
    .tmr_count     (tmr_count)
);

// File: tb/edge_watchdog_test.sv
module edge_watchdog_test;

    localparam int T   = 20;
    localparam int SYN = 2;
    localparam int HI  = SYN + T;      // last edge still high after a kick
    localparam int LO  = SYN + T + 1;  // first edge low after a kick

    typedef struct {
        int    at;
        logic  val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0;
    logic drv = 1'b1;
    logic sup = 1'b1;
    logic srst = 1'b0;
    logic wdog_n;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    exp_t sb[$];

    edge_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(SYN)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .kick_i        (kick),
        .kick_drv_i    (drv),
        .supply_ok_i   (sup),
        .sys_rst_act_i (srst),
        .wdog_n_o      (wdog_n)
    );

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic expect_at(input int at, input logic val, input string req);
        exp_t e;
        e.at = at; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations as their cycle comes due
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.at < cyc) begin
                total++; bad++;
                $display("FAIL %s missed slot actual=late expected=%0d", e.req, e.at);
            end else begin
                check(wdog_n, e.val, e.req);
            end
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    initial begin
        int t;
        int t2;
        step(3);
        check(wdog_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        step(1);
        check(wdog_n, 1'b1, "R1 after reset");
        expect_at(cyc + 3*T, 1'b1, "R1 disarmed until first edge");
        step(3*T + 2);

        // rising kick and expiry
        kick = 1'b1; t = cyc;
        expect_at(t + HI, 1'b1, "R3 high before expiry");
        expect_at(t + LO, 1'b0, "R3 low at expiry");
        expect_at(t + LO + 12, 1'b0, "R4 held low");
        step(LO + 13);

        // falling kick clears and restarts
        kick = 1'b0; t = cyc;
        expect_at(t + SYN, 1'b0, "R4 low until edge taken");
        expect_at(t + SYN + 1, 1'b1, "R2 falling edge clears");
        expect_at(t + HI, 1'b1, "R2 falling restart high");
        expect_at(t + LO, 1'b0, "R2 falling restart expiry");
        step(LO + 2);

        // re-kick before expiry reschedules
        t = cyc; t2 = t + 10;
        expect_at(t + SYN + 1, 1'b1, "R2 cleared");
        expect_at(t + LO, 1'b1, "R2 first deadline moved");
        expect_at(t2 + HI, 1'b1, "R2 rescheduled high");
        expect_at(t2 + LO, 1'b0, "R2 rescheduled expiry");
        kick = 1'b1;
        step(10);
        kick = 1'b0;
        step(LO + 12);

        // system reset hold-off
        srst = 1'b1; t = cyc;
        expect_at(t + 1, 1'b1, "R5 reset clears output");
        step(2);
        for (int i = 0; i < 10; i++) begin
            kick = ~kick;
            expect_at(cyc + 3, 1'b1, "R5 kicks ignored in reset");
            step(4);
        end
        srst = 1'b0; t = cyc;
        expect_at(t + T + 6, 1'b1, "R5 no count without edge");
        step(T + 8);
        kick = ~kick; t = cyc;
        expect_at(t + LO, 1'b0, "R5 counts after edge");
        step(LO + 2);

        // undriven kick line
        kick = ~kick; t = cyc;
        expect_at(t + SYN + 1, 1'b1, "R6 cleared by kick");
        step(5);
        drv = 1'b0; t = cyc;
        expect_at(t + 1, 1'b1, "R6 undriven holds");
        step(2);
        for (int i = 0; i < 10; i++) begin
            kick = ~kick;
            expect_at(cyc + 3, 1'b1, "R6 edges ignored while undriven");
            step(4);
        end
        drv = 1'b1; t = cyc;
        expect_at(t + T + 6, 1'b1, "R6 disarmed after drive returns");
        step(T + 8);
        kick = ~kick; t = cyc;
        expect_at(t + LO, 1'b0, "R6 counts after edge");
        step(LO + 2);

        // one-cycle pulse: two edges
        kick = ~kick; t = cyc;
        expect_at(t + SYN + 1, 1'b1, "R8 first edge clears");
        expect_at(t + LO, 1'b1, "R8 second edge restarts");
        expect_at(t + 1 + LO, 1'b0, "R8 expiry from second edge");
        step(1);
        kick = ~kick;
        step(LO + 4);

        // supply loss while counting
        kick = ~kick; t = cyc;
        expect_at(t + SYN + 1, 1'b1, "R7 pre-check cleared");
        step(5);
        sup = 1'b0; #3;
        check(wdog_n, 1'b0, "R7 immediate low");
        step(4);
        check(wdog_n, 1'b0, "R7 held low");
        sup = 1'b1; #3;
        check(wdog_n, 1'b1, "R7 immediate high");
        expect_at(cyc + T + 6, 1'b1, "R7 supply loss disarms");
        step(T + 8);

        // supply glitch while expired
        kick = ~kick;
        step(LO + 3);
        check(wdog_n, 1'b0, "R4 expired before glitch");
        sup = 1'b0; #3;
        check(wdog_n, 1'b0, "R7 low on loss");
        step(1);
        sup = 1'b1; #3;
        check(wdog_n, 1'b1, "R7 high with no delay");

        step(5);
        while (sb.size() > 0) step(1);
        step(2);
        finish_up();
    end

endmodule